// File: doc/BRIEF.md
# Pushbutton Debouncer with Stability Counter

This block turns the chattering level of a mechanical pushbutton into a clean, steady level that the rest of the design can use. The raw input may change at any time. It is sampled by two registers in series. When the two samples differ, a stability counter is cleared. While they agree, the counter counts up. When the counter's top bit becomes set, the settled sample is copied into the output register. A one-clock press strobe can be turned on by a parameter. It marks each rising transition of the clean level.

The counter width `CNT_W` sets the settling window H = 2^(CNT_W-1) clock cycles. The default of 19 bits gives H = 262144 cycles, which is about 5 ms at a 50 MHz system clock. After a change, the input must hold its new value for H+1 consecutive samples before the output follows. Any burst of glitches whose steady stretches are all H samples or shorter leaves the output untouched.

Top module: `btn_debouncer`

## Requirements
- R1: While `rst` is high at a rising clock edge, both sample registers, the stability counter, `btn_level` and `btn_press` are cleared to 0.
- R2: `btn_raw` is captured on every rising edge into a first sample register, which is copied on the next edge into a second sample register. Only these two registered samples feed the decision logic.
- R3: Any cycle in which the two samples differ clears the stability counter to 0. A burst of input changes in which no steady stretch exceeds H samples never changes `btn_level`.
- R4: While the samples agree and the counter's top bit is 0, the counter increases by one each cycle. After a clean step on `btn_raw` first sampled at edge k, `btn_level` takes the new value at edge k+H+2, and at no earlier edge. This holds for both rising and falling steps.
- R5: Once the counter's top bit is set, the counter holds its value with no wrap for as long as the samples agree. An input held steady for longer than 2^CNT_W cycles produces no output change and no press strobe.
- R6: When the press strobe is enabled (`PRESS_EN`=1), `btn_press` is 1 for exactly the one cycle in which `btn_level` goes from 0 to 1. It stays 0 on a 1-to-0 transition and at all other times.
- R7: Boundary case: an input pulse held for exactly H samples is ignored. A pulse held for H+1 samples is passed to `btn_level`, appearing at edge k+H+2.
- R8: `btn_level` can change only on an edge at which the counter's top bit was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw, asynchronous button level |
| btn_level | output | 1 | Debounced button level (registered) |
| btn_press | output | 1 | One-cycle strobe on a 0-to-1 transition of `btn_level` (registered; tied low when `PRESS_EN`=0) |

## Verification
A change on `btn_raw` that is first sampled at edge k must appear on `btn_level` at edge k+H+2 exactly. `btn_press` rises on that same edge when the transition is 0-to-1. The driver tracks the length of each steady input run. As soon as a run reaches H+1 samples with a value that differs from the expected level, it queues an event due two edges later. The monitor samples on falling clock edges. It matches each observed level change against the head of the queue by edge number and value. It flags any change that was not expected, any event that passes its due edge without the output changing, and any press strobe that comes without a rising level.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  // Default counter width: 2^18 cycles of agreement, about 5 ms at 50 MHz.
  localparam int unsigned DEF_CNT_W = 19;

  typedef struct packed {
    logic cur;   // newest registered sample
    logic prev;  // sample one cycle older
  } samp_pair_t;
endpackage

// File: rtl/dbnc_sampler.sv
module dbnc_sampler
  import dbnc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_in,
  output samp_pair_t samp
);
  logic s_cur_q;
  logic s_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cur_q  <= 1'b0;
      s_prev_q <= 1'b0;
    end else begin
      s_cur_q  <= raw_in;
      s_prev_q <= s_cur_q;
    end
  end

  assign samp.cur  = s_cur_q;
  assign samp.prev = s_prev_q;
endmodule

// File: rtl/dbnc_stab_counter.sv
module dbnc_stab_counter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mismatch,
  output logic [CNT_W-1:0] count,
  output logic             settled
);
  localparam int unsigned TOP = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (mismatch) begin
      cnt_q <= '0;
    end else if (!cnt_q[TOP]) begin
      cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  assign count   = cnt_q;
  assign settled = cnt_q[TOP];
endmodule

// File: rtl/dbnc_out_stage.sv
module dbnc_out_stage #(
  parameter bit PRESS_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic stable_val,
  output logic level,
  output logic press
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst)       level_q <= 1'b0;
    else if (load) level_q <= stable_val;
  end

  generate
    if (PRESS_EN) begin : g_press
      logic press_q;
      always_ff @(posedge clk) begin
        if (rst) press_q <= 1'b0;
        else     press_q <= load & stable_val & ~level_q;
      end
      assign press = press_q;
    end else begin : g_no_press
      assign press = 1'b0;
    end
  endgenerate

  assign level = level_q;
endmodule

// File: rtl/btn_debouncer.sv
module btn_debouncer
  import dbnc_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter bit          PRESS_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_level,
  output logic btn_press
);
  samp_pair_t       samp;
  logic             diff;
  logic [CNT_W-1:0] stab_cnt;
  logic             settled;

  dbnc_sampler u_sampler (
    .clk    (clk),
    .rst    (rst),
    .raw_in (btn_raw),
    .samp   (samp)
  );

  assign diff = samp.cur ^ samp.prev;

  dbnc_stab_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .mismatch (diff),
    .count    (stab_cnt),
    .settled  (settled)
  );

  // The older sample is loaded: in the cycle that a change reaches the
  // newer sample, the older one still holds the settled value.
  dbnc_out_stage #(.PRESS_EN(PRESS_EN)) u_out (
    .clk        (clk),
    .rst        (rst),
    .load       (settled),
    .stable_val (samp.prev),
    .level      (btn_level),
    .press      (btn_press)
  );
endmodule

// File: rtl/btn_debouncer_chk.sv
module btn_debouncer_chk #(
  parameter int unsigned CNT_W    = 19,
  parameter bit          PRESS_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             s_cur,
  input logic             s_prev,
  input logic [CNT_W-1:0] cnt,
  input logic             level,
  input logic             press
);
  localparam int unsigned TOP = CNT_W - 1;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!level && !press && cnt == '0 && !s_cur && !s_prev));

  a_r2_sample_chain: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> s_prev == $past(s_cur));

  a_r3_change_clears: assert property (@(posedge clk) disable iff (rst)
    (s_cur != s_prev) |=> cnt == '0);

  a_r4_count_up: assert property (@(posedge clk) disable iff (rst)
    (s_cur == s_prev && !cnt[TOP]) |=> cnt == $past(cnt) + 1'b1);

  a_r5_hold_at_top: assert property (@(posedge clk) disable iff (rst)
    (s_cur == s_prev && cnt[TOP]) |=> $stable(cnt));

  a_r8_load_gated: assert property (@(posedge clk) disable iff (rst)
    !cnt[TOP] |=> $stable(level));

  generate
    if (PRESS_EN) begin : g_press_chk
      a_r6_press_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |-> press);
      a_r6_press_only_rise: assert property (@(posedge clk) disable iff (rst)
        press |-> $rose(level));
    end
  endgenerate
endmodule

bind btn_debouncer btn_debouncer_chk #(.CNT_W(CNT_W), .PRESS_EN(PRESS_EN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .s_cur  (samp.cur),
  .s_prev (samp.prev),
  .cnt    (stab_cnt),
  .level  (btn_level),
  .press  (btn_press)
);

// File: tb/btn_debouncer_tb.sv
module btn_debouncer_tb;
  localparam int unsigned CNT_W = 6;
  localparam int H = 2 ** (CNT_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic btn_level;
  logic btn_press;

  always #2.5 clk = ~clk;

  btn_debouncer #(.CNT_W(CNT_W), .PRESS_EN(1'b1)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .btn_raw   (btn_raw),
    .btn_level (btn_level),
    .btn_press (btn_press)
  );

  typedef struct {
    int   due;
    logic val;
  } ev_t;

  ev_t  exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  logic run_v = 1'b0;
  int   run_len = H + 2;
  logic exp_lvl = 1'b0;
  logic prev_lvl = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Driver: apply value v for n cycles and queue the output events it implies.
  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      btn_raw = v;
      if (v != run_v) begin
        run_v   = v;
        run_len = 1;
      end else if (run_len <= H + 1) begin
        run_len++;
      end
      if (run_len == H + 1 && v != exp_lvl) begin
        exp_q.push_back('{due: cyc + 3, val: v});
        exp_lvl = v;
      end
    end
  endtask

  // Glitch burst: steady stretches all no longer than H samples.
  task automatic burst(input logic base, input int n);
    for (int i = 0; i < n; i++) begin
      drive(~base, 1 + (i * 7) % H);
      drive(base, 1 + (i * 5) % H);
    end
  endtask

  // Monitor: compare level changes and strobes against the queue.
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_q.size() > 0 && exp_q[0].due < cyc) begin
        check(1'b0, "R4 missed output change", cyc, exp_q[0].due);
        void'(exp_q.pop_front());
      end
      if (btn_level != prev_lvl) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected output change", btn_level, prev_lvl);
        end else begin
          check(exp_q[0].due == cyc, "R4 change edge", cyc, exp_q[0].due);
          check(exp_q[0].val == btn_level, "R4 change value", btn_level, exp_q[0].val);
          void'(exp_q.pop_front());
        end
        check(btn_press == btn_level, "R6 strobe on transition", btn_press, btn_level);
      end else if (btn_press) begin
        check(1'b0, "R6 strobe without rising level", btn_press, 0);
      end
      prev_lvl <= btn_level;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(btn_level == 1'b0, "R1 level in reset", btn_level, 0);
    check(btn_press == 1'b0, "R1 press in reset", btn_press, 0);
    rst = 1'b0;
    drive(1'b0, H + 10);
    check(btn_level == 1'b0, "R1 level after reset", btn_level, 0);
    drive(1'b1, 3 * H);                 // R2 R4 R6 clean rising step
    check(btn_level == 1'b1, "R4 level after rise", btn_level, 1);
    burst(1'b1, 12);                    // R3 glitches while high
    drive(1'b1, 2 * H);
    check(btn_level == 1'b1, "R3 level after high burst", btn_level, 1);
    drive(1'b0, H);                     // R7 pulse of H samples: ignored
    drive(1'b1, 2 * H);
    check(btn_level == 1'b1, "R7 H-sample pulse ignored", btn_level, 1);
    drive(1'b0, H + 1);                 // R7 pulse of H+1 samples: passed
    drive(1'b1, 3);
    check(btn_level == 1'b0, "R7 H+1-sample pulse passed", btn_level, 0);
    drive(1'b1, 2 * H);
    drive(1'b0, 3 * H);                 // R4 R6 falling step, no strobe
    check(btn_level == 1'b0, "R4 level after fall", btn_level, 0);
    burst(1'b0, 12);                    // R3 glitches while low
    drive(1'b0, 5 * (2 ** CNT_W));      // R5 long hold, no wrap effect
    check(btn_level == 1'b0, "R5 level after long hold", btn_level, 0);
    drive(1'b1, 5 * (2 ** CNT_W));
    check(btn_level == 1'b1, "R5 level after long high hold", btn_level, 1);
    drive(1'b1, 4);
    check(exp_q.size() == 0, "R2 all queued events seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule